// File: doc/BRIEF.md
# Hall Sensor Commutation Decoder

This block turns the three rotor-position sensor levels of a brushless three-phase motor into a phase selection for the bridge. It picks exactly one high-side leg to source current and one low-side leg to sink it. It understands two sensor spacings, 120 degrees and 60 degrees, and both directions of rotation. The reverse direction is produced by decoding the inverted sensor code against the same tables.

On top of normal commutation the block applies a fixed ladder of overrides. In priority order these are: a supply undervoltage fault, an unusable sensor code, a shorted-brake command that grounds every winding, and a regenerative-brake request that pulses all low sides together at an externally generated brake duty. A separate mask blanks only the high sides. The phase enables are registered and go to a downstream PWM sequencer.

Top module: `hall_commutator`

## Requirements
- R1: The sensor code is written hall[2] hall[1] hall[0], and output vectors are ordered {W,V,U}. With `hsel`=1 (120 degree spacing), `fr`=0 and no override, the (high, low) pairs are: 010 gives U/V, 011 gives U/W, 001 gives V/W, 101 gives V/U, 100 gives W/U, 110 gives W/V.
- R2: With `hsel`=0 (60 degree spacing), `fr`=0 and no override, the pairs are: 000 gives U/V, 100 gives U/W, 110 gives V/W, 111 gives V/U, 011 gives W/U, 001 gives W/V.
- R3: With `fr`=1, each table is indexed by the bitwise complement of the sensor code, and the resulting pairs are the same.
- R4: In 120 degree spacing, the code 111 turns every output off, in either direction.
- R5: In 120 degree spacing, the code 000 turns every output off, in either direction.
- R6: In 60 degree spacing, the codes 010 and 101 are unusable and turn every output off.
- R7: While `lv_fault`=1, every output is off, whatever the other inputs are.
- R8: An unusable code takes precedence over both brakes, so every output is off.
- R9: With `sb`=1, a usable code and no fault, all three low-side enables are 1 and all high-side enables are 0. This holds even when `br_n`=0.
- R10: With `br_n`=0, `sb`=0, a usable code and no fault, all three low-side enables equal `brake_pwm` and all high-side enables are 0.
- R11: `hi_disable`=1 forces every high-side enable to 0 and leaves the low-side enables as they would otherwise be.
- R12: The outputs are registered. An input change shows one clock later, synchronous reset clears every output, at most one high-side enable is ever 1, and outside braking at most one low-side enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall | input | 3 | Sensor levels, hall[2] first sensor |
| hsel | input | 1 | 1 = 120 degree spacing, 0 = 60 degree |
| fr | input | 1 | Direction; 1 complements the code |
| sb | input | 1 | Shorted-brake command |
| br_n | input | 1 | Regenerative-brake request, active low |
| brake_pwm | input | 1 | Brake duty pulse for the low sides |
| lv_fault | input | 1 | Supply undervoltage fault |
| hi_disable | input | 1 | Masks all high-side enables |
| uh | output | 1 | High-side enable, phase U |
| vh | output | 1 | High-side enable, phase V |
| wh | output | 1 | High-side enable, phase W |
| ul | output | 1 | Low-side enable, phase U |
| vl | output | 1 | Low-side enable, phase V |
| wl | output | 1 | Low-side enable, phase W |

## Verification
The block's only structural constants are the three-phase and three-sensor widths in the package, and the bench builds it with those defaults. At that size the whole input space of the decoder is small: all eight codes under both spacings and both directions make 32 cases, and the bench walks every one of them. This covers each table row and each unusable code. Directed steps then stack the overrides pairwise to expose the priority order. They also toggle the brake pulse under regenerative braking and watch one input change across a single clock edge to confirm the registered latency.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned NPH    = 3;
  localparam int unsigned HALL_W = 3;

  typedef enum logic [1:0] {PH_U = 2'd0, PH_V = 2'd1, PH_W = 2'd2, PH_NONE = 2'd3} phase_e;

  typedef struct packed {
    phase_e hi;
    phase_e lo;
    logic   valid;
  } step_t;

  typedef logic [NPH-1:0]    phvec_t;
  typedef logic [HALL_W-1:0] hcode_t;
endpackage

// File: rtl/hc_decode.sv
module hc_decode
  import hc_pkg::*;
(
  input  hcode_t hall,
  input  logic   hsel,
  input  logic   fr,
  output step_t  step
);
  hcode_t code;

  // Reverse rotation reuses the forward tables on the inverted code
  assign code = fr ? ~hall : hall;

  always_comb begin
    step = '{hi: PH_NONE, lo: PH_NONE, valid: 1'b0};
    if (hsel) begin
      unique case (code)
        3'b010: step = '{hi: PH_U, lo: PH_V, valid: 1'b1};
        3'b011: step = '{hi: PH_U, lo: PH_W, valid: 1'b1};
        3'b001: step = '{hi: PH_V, lo: PH_W, valid: 1'b1};
        3'b101: step = '{hi: PH_V, lo: PH_U, valid: 1'b1};
        3'b100: step = '{hi: PH_W, lo: PH_U, valid: 1'b1};
        3'b110: step = '{hi: PH_W, lo: PH_V, valid: 1'b1};
        default: step = '{hi: PH_NONE, lo: PH_NONE, valid: 1'b0};
      endcase
    end else begin
      unique case (code)
        3'b000: step = '{hi: PH_U, lo: PH_V, valid: 1'b1};
        3'b100: step = '{hi: PH_U, lo: PH_W, valid: 1'b1};
        3'b110: step = '{hi: PH_V, lo: PH_W, valid: 1'b1};
        3'b111: step = '{hi: PH_V, lo: PH_U, valid: 1'b1};
        3'b011: step = '{hi: PH_W, lo: PH_U, valid: 1'b1};
        3'b001: step = '{hi: PH_W, lo: PH_V, valid: 1'b1};
        default: step = '{hi: PH_NONE, lo: PH_NONE, valid: 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/hc_arbiter.sv
module hc_arbiter
  import hc_pkg::*;
(
  input  step_t  step,
  input  logic   sb,
  input  logic   br_n,
  input  logic   brake_pwm,
  input  logic   lv_fault,
  input  logic   hi_disable,
  output phvec_t hi_nxt,
  output phvec_t lo_nxt
);
  phvec_t hi_sel, lo_sel;

  // Phase index to one-hot, one bit per leg
  for (genvar p = 0; p < NPH; p++) begin : g_leg
    assign hi_sel[p] = step.valid && (step.hi == phase_e'(2'(p)));
    assign lo_sel[p] = step.valid && (step.lo == phase_e'(2'(p)));
  end

  always_comb begin
    hi_nxt = '0;
    lo_nxt = '0;
    if (lv_fault || !step.valid) begin
      hi_nxt = '0;
      lo_nxt = '0;
    end else if (sb) begin
      lo_nxt = '1;
    end else if (!br_n) begin
      lo_nxt = {NPH{brake_pwm}};
    end else begin
      hi_nxt = hi_disable ? '0 : hi_sel;
      lo_nxt = lo_sel;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hall,
  input  logic       hsel,
  input  logic       fr,
  input  logic       sb,
  input  logic       br_n,
  input  logic       brake_pwm,
  input  logic       lv_fault,
  input  logic       hi_disable,
  output logic       uh,
  output logic       vh,
  output logic       wh,
  output logic       ul,
  output logic       vl,
  output logic       wl
);
  step_t  dec_step;
  phvec_t hi_nxt, lo_nxt;
  phvec_t hi_q, lo_q;

  hc_decode u_decode (
    .hall (hall),
    .hsel (hsel),
    .fr   (fr),
    .step (dec_step)
  );

  hc_arbiter u_arbiter (
    .step       (dec_step),
    .sb         (sb),
    .br_n       (br_n),
    .brake_pwm  (brake_pwm),
    .lv_fault   (lv_fault),
    .hi_disable (hi_disable),
    .hi_nxt     (hi_nxt),
    .lo_nxt     (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assign {wh, vh, uh} = hi_q;
  assign {wl, vl, ul} = lo_q;

  // R12: never two high sides at once
  assert_hi_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uh, vh, wh}));

  // R12: single low side outside braking
  assert_lo_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    (!sb && br_n) |=> $onehot0({ul, vl, wl}));

  // R7: undervoltage blanks everything on the next clock
  assert_lv_off_R7: assert property (@(posedge clk) disable iff (rst)
    lv_fault |=> ({uh, vh, wh, ul, vl, wl} == 6'b0));

  // R4: all-high code in 120 degree spacing blanks everything
  assert_inv_off_R4: assert property (@(posedge clk) disable iff (rst)
    (hsel && hall == 3'b111) |=> ({uh, vh, wh, ul, vl, wl} == 6'b0));

  // R9: shorted brake grounds all windings
  assert_sb_R9: assert property (@(posedge clk) disable iff (rst)
    (!lv_fault && dec_step.valid && sb) |=> ({ul, vl, wl} == 3'b111 && {uh, vh, wh} == 3'b000));

  // R10: regenerative brake follows the duty pulse on every low side
  assert_regen_R10: assert property (@(posedge clk) disable iff (rst)
    (!lv_fault && dec_step.valid && !sb && !br_n) |=>
      ({ul, vl, wl} == {3{$past(brake_pwm)}} && {uh, vh, wh} == 3'b000));

  // R11: the mask leaves no high side on
  assert_hidis_R11: assert property (@(posedge clk) disable iff (rst)
    hi_disable |=> ({uh, vh, wh} == 3'b000));
endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] hall;
  logic       hsel, fr, sb, br_n, brake_pwm, lv_fault, hi_disable;
  logic       uh, vh, wh, ul, vl, wl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hall_commutator i_hall_commutator (
    .clk(clk), .rst(rst), .hall(hall), .hsel(hsel), .fr(fr), .sb(sb),
    .br_n(br_n), .brake_pwm(brake_pwm), .lv_fault(lv_fault),
    .hi_disable(hi_disable),
    .uh(uh), .vh(vh), .wh(wh), .ul(ul), .vl(vl), .wl(wl)
  );

  // {hsel, code, exp_hi{W,V,U}, exp_lo{W,V,U}} for fr=0
  localparam logic [9:0] VEC [16] = '{
    {1'b1, 3'b010, 3'b001, 3'b010},
    {1'b1, 3'b011, 3'b001, 3'b100},
    {1'b1, 3'b001, 3'b010, 3'b100},
    {1'b1, 3'b101, 3'b010, 3'b001},
    {1'b1, 3'b100, 3'b100, 3'b001},
    {1'b1, 3'b110, 3'b100, 3'b010},
    {1'b1, 3'b111, 3'b000, 3'b000},
    {1'b1, 3'b000, 3'b000, 3'b000},
    {1'b0, 3'b000, 3'b001, 3'b010},
    {1'b0, 3'b100, 3'b001, 3'b100},
    {1'b0, 3'b110, 3'b010, 3'b100},
    {1'b0, 3'b111, 3'b010, 3'b001},
    {1'b0, 3'b011, 3'b100, 3'b001},
    {1'b0, 3'b001, 3'b100, 3'b010},
    {1'b0, 3'b010, 3'b000, 3'b000},
    {1'b0, 3'b101, 3'b000, 3'b000}
  };

  task automatic check(input string tag, input logic [2:0] exp_hi, input logic [2:0] exp_lo);
    checks++;
    if ({wh, vh, uh} !== exp_hi || {wl, vl, ul} !== exp_lo) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, {wh, vh, uh}, {wl, vl, ul}, exp_hi, exp_lo);
    end
  endtask

  // drive at a falling edge, result registered at the next rising edge, sample at the falling edge after
  task automatic step_in(input logic [2:0] h);
    @(negedge clk);
    hall = h;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; hall = 3'b000; hsel = 1'b1; fr = 1'b0; sb = 1'b0; br_n = 1'b1;
    brake_pwm = 1'b0; lv_fault = 1'b0; hi_disable = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset", 3'b000, 3'b000);
    rst = 1'b0;

    // exhaustive table walk, both directions
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        hsel = VEC[i][9];
        fr   = d[0];
        hall = d[0] ? ~VEC[i][8:6] : VEC[i][8:6];
        @(negedge clk);
        if (VEC[i][5:0] == 6'b0)
          check(VEC[i][9] ? (VEC[i][8:6] == 3'b111 ? "R4 all-high" : "R5 all-low") : "R6 unused", 3'b000, 3'b000);
        else if (d == 1)
          check("R3 reverse", VEC[i][5:3], VEC[i][2:0]);
        else
          check(VEC[i][9] ? "R1 120deg" : "R2 60deg", VEC[i][5:3], VEC[i][2:0]);
      end
    end

    // raw all-high with fr=1 in 120 spacing
    fr = 1'b1; hsel = 1'b1;
    step_in(3'b111);
    check("R4 all-high reverse", 3'b000, 3'b000);
    fr = 1'b0;

    // R12 one-clock latency
    step_in(3'b010);
    @(negedge clk);
    hall = 3'b101;
    #1;
    check("R12 before edge", 3'b001, 3'b010);
    @(negedge clk);
    check("R12 after edge", 3'b010, 3'b001);

    // R7 fault beats shorted brake
    @(negedge clk); lv_fault = 1'b1; sb = 1'b1;
    @(negedge clk);
    check("R7 fault", 3'b000, 3'b000);
    @(negedge clk); lv_fault = 1'b0; sb = 1'b0;
    @(negedge clk);
    check("R7 release", 3'b010, 3'b001);

    // R9 shorted brake, also over regenerative request
    @(negedge clk); sb = 1'b1;
    @(negedge clk);
    check("R9 shorted", 3'b000, 3'b111);
    @(negedge clk); br_n = 1'b0; brake_pwm = 1'b0;
    @(negedge clk);
    check("R9 over regen", 3'b000, 3'b111);

    // R8 unusable code beats shorted brake
    step_in(3'b000);
    check("R8 invalid over brake", 3'b000, 3'b000);

    // R10 regenerative brake follows the pulse
    @(negedge clk); sb = 1'b0; hall = 3'b011; brake_pwm = 1'b1;
    @(negedge clk);
    check("R10 pulse high", 3'b000, 3'b111);
    @(negedge clk); brake_pwm = 1'b0;
    @(negedge clk);
    check("R10 pulse low", 3'b000, 3'b000);
    @(negedge clk); br_n = 1'b1;

    // R11 high-side mask
    @(negedge clk); hi_disable = 1'b1; hall = 3'b110;
    @(negedge clk);
    check("R11 masked", 3'b000, 3'b010);
    @(negedge clk); hi_disable = 1'b0;
    @(negedge clk);
    check("R11 unmasked", 3'b100, 3'b010);

    // R12 synchronous reset clears a live output
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R12 reset clears", 3'b000, 3'b000);
    rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule